// File: doc/BRIEF.md
# Background Line-Unlock Sequencer

This block releases cache lines that an earlier lockdown-by-line period pinned in place. Software starts it by writing a mask with one bit per cache way. From then on it runs on its own. For every selected way, lowest way first, it steps through all set indices in ascending order. At each index it reads the tag entry over a valid/ready port, clears the per-line lock flag held in tag bit 21, and writes the entry back. All other tag bits are written back unchanged.

Software follows progress by polling a 32-bit status word. Bit n stays set while way n still has lines to visit. The upper half always reads zero. While any way is pending, the block refuses other background maintenance requests with a slave-error indication and does not start them. A second start that arrives while the block is busy is dropped and raises no error. The tag RAM, its arbitration and the other maintenance operations sit outside this block.

Top module: `line_unlock_engine`

## Requirements
- R1: `status` bit n (n below `WAYS`, at most 16) is the in-progress flag of way n, and bits 31:16 always read 0.
- R2: While and after a synchronous reset, `status` is 0, `busy` is 0 and neither `tag_rd_valid` nor `tag_wr_valid` is asserted.
- R3: A start (`start_valid` high while `busy` is low) makes `status` equal the zero-extended `start_mask` on the next cycle. `busy` is high exactly when `status` is non-zero, so an all-zero mask leaves the block idle.
- R4: For each selected way, in ascending way order, the block reads and then writes every index from 0 to `SETS-1` in ascending order, one read and one write per index. Unselected ways are never addressed.
- R5: Each written tag equals the tag returned by the read of the same way and index, with bit 21 forced to 0. Every other bit is unchanged.
- R6: The status bit of a way falls on the cycle after the write to its index `SETS-1` is accepted, and it does not fall earlier. `busy` falls together with the last status bit.
- R7: A maintenance request (`maint_valid`) while `busy` is high gives `maint_err`=1 and `maint_go`=0 in the same cycle. While `busy` is low it gives `maint_go`=1 and `maint_err`=0.
- R8: A start while `busy` is high is ignored. No status bit rises and no extra way is processed.
- R9: While `tag_rd_valid` or `tag_wr_valid` is high without its ready, the valid stays high and `tag_way`/`tag_idx` hold steady on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Start command strobe |
| start_mask | input | WAYS | One bit per way to unlock |
| maint_valid | input | 1 | Another background maintenance request |
| maint_go | output | 1 | Request may start (OKAY) |
| maint_err | output | 1 | Request refused with slave error |
| status | output | 32 | Per-way in-progress flags, upper half zero |
| busy | output | 1 | Any way still in progress |
| tag_rd_valid | output | 1 | Tag read request |
| tag_rd_ready | input | 1 | Tag read accepted |
| tag_rsp_valid | input | 1 | Tag read data valid |
| tag_rsp_data | input | TAG_W | Tag read data |
| tag_wr_valid | output | 1 | Tag write request |
| tag_wr_ready | input | 1 | Tag write accepted |
| tag_wr_data | output | TAG_W | Tag write data |
| tag_way | output | $clog2(WAYS) | Way addressed by the current request |
| tag_idx | output | $clog2(SETS) | Set index addressed by the current request |

## Verification
Two events can land in the same cycle: the accepted write to the final index of the final way, and a maintenance request. In that cycle the final status bit has not yet fallen, so the request must still be refused. One cycle later it must be granted. The bench waits for the final write with its ready high, raises `maint_valid` in that cycle and checks the error flag. On the next cycle it checks that the grant comes and the status word is zero. A start that arrives mid-run is tested in the same spirit: the bench confirms that neither the status word nor the recorded write sequence changes.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

    localparam int STATUS_W = 32;
    localparam int MAX_WAYS = 16;
    localparam int LOCK_BIT = 21;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_READ  = 2'd1,
        SEQ_WAIT  = 2'd2,
        SEQ_WRITE = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic step;
        logic way_done;
    } seq_evt_t;

    typedef struct packed {
        logic go;
        logic err;
    } maint_resp_t;

endpackage

// File: rtl/unl_way_pick.sv
module unl_way_pick #(
    parameter int WAYS  = 16,
    parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]  pending,
    output logic [WAY_W-1:0] cur_way,
    output logic             any,
    output logic             rest_any
);
    logic [WAYS-1:0] cur_onehot;

    always_comb begin
        cur_way    = '0;
        cur_onehot = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (pending[w]) begin
                cur_way    = WAY_W'(w);
                cur_onehot = WAYS'(1) << w;
            end
        end
    end

    assign any      = |pending;
    assign rest_any = |(pending & ~cur_onehot);
endmodule

// File: rtl/unl_idx_counter.sv
module unl_idx_counter #(
    parameter int SETS  = 2048,
    parameter int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SETS - 1);

    assign last = (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (step) begin
            idx <= last ? '0 : idx + IDX_W'(1);
        end
    end
endmodule

// File: rtl/unl_status_reg.sv
module unl_status_reg #(
    parameter int WAYS  = 16,
    parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WAYS-1:0]  load_mask,
    input  logic             clr,
    input  logic [WAY_W-1:0] clr_way,
    output logic [WAYS-1:0]  pending
);
    logic [WAYS-1:0] clr_vec;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_clr
            assign clr_vec[w] = clr && (clr_way == WAY_W'(w));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
        end else if (load) begin
            pending <= load_mask;
        end else begin
            pending <= pending & ~clr_vec;
        end
    end
endmodule

// File: rtl/unl_tag_seq.sv
module unl_tag_seq
    import unlock_pkg::*;
#(
    parameter int TAG_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             kick,
    input  logic             rest_any,
    input  logic             last_idx,
    output logic             rd_valid,
    input  logic             rd_ready,
    input  logic             rsp_valid,
    input  logic [TAG_W-1:0] rsp_data,
    output logic             wr_valid,
    input  logic             wr_ready,
    output logic [TAG_W-1:0] wr_data,
    output seq_evt_t         evt
);
    localparam logic [TAG_W-1:0] LOCK_MASK = TAG_W'(1) << LOCK_BIT;

    seq_state_e      state, state_nx;
    logic [TAG_W-1:0] hold_q;

    assign rd_valid = (state == SEQ_READ);
    assign wr_valid = (state == SEQ_WRITE);
    assign wr_data  = hold_q & ~LOCK_MASK;

    always_comb begin
        state_nx     = state;
        evt.step     = 1'b0;
        evt.way_done = 1'b0;
        unique case (state)
            SEQ_IDLE:  if (kick) state_nx = SEQ_READ;
            SEQ_READ:  if (rd_ready) state_nx = SEQ_WAIT;
            SEQ_WAIT:  if (rsp_valid) state_nx = SEQ_WRITE;
            SEQ_WRITE: begin
                if (wr_ready) begin
                    evt.step = 1'b1;
                    if (last_idx) begin
                        evt.way_done = 1'b1;
                        state_nx     = rest_any ? SEQ_READ : SEQ_IDLE;
                    end else begin
                        state_nx = SEQ_READ;
                    end
                end
            end
            default:   state_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            hold_q <= '0;
        end else begin
            state <= state_nx;
            if (state == SEQ_WAIT && rsp_valid) hold_q <= rsp_data;
        end
    end
endmodule

// File: rtl/unl_maint_gate.sv
module unl_maint_gate
    import unlock_pkg::*;
(
    input  logic        busy,
    input  logic        req,
    output maint_resp_t resp
);
    assign resp.go  = req && !busy;
    assign resp.err = req && busy;
endmodule

// File: rtl/line_unlock_engine.sv
module line_unlock_engine
    import unlock_pkg::*;
#(
    parameter int WAYS  = 16,
    parameter int SETS  = 2048,
    parameter int TAG_W = 24,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_valid,
    input  logic [WAYS-1:0]     start_mask,
    input  logic                maint_valid,
    output logic                maint_go,
    output logic                maint_err,
    output logic [STATUS_W-1:0] status,
    output logic                busy,
    output logic                tag_rd_valid,
    input  logic                tag_rd_ready,
    input  logic                tag_rsp_valid,
    input  logic [TAG_W-1:0]    tag_rsp_data,
    output logic                tag_wr_valid,
    input  logic                tag_wr_ready,
    output logic [TAG_W-1:0]    tag_wr_data,
    output logic [WAY_W-1:0]    tag_way,
    output logic [IDX_W-1:0]    tag_idx
);
    logic [WAYS-1:0] pending;
    logic            any_pending, rest_any, last_idx, start_ok;
    seq_evt_t        evt;
    maint_resp_t     mresp;

    assign start_ok = start_valid && !any_pending;
    assign busy     = any_pending;
    assign status   = STATUS_W'(pending);

    unl_way_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
        .pending  (pending),
        .cur_way  (tag_way),
        .any      (any_pending),
        .rest_any (rest_any)
    );

    unl_status_reg #(.WAYS(WAYS), .WAY_W(WAY_W)) u_status (
        .clk       (clk),
        .rst       (rst),
        .load      (start_ok),
        .load_mask (start_mask),
        .clr       (evt.way_done),
        .clr_way   (tag_way),
        .pending   (pending)
    );

    unl_idx_counter #(.SETS(SETS), .IDX_W(IDX_W)) u_idx (
        .clk  (clk),
        .rst  (rst),
        .step (evt.step),
        .idx  (tag_idx),
        .last (last_idx)
    );

    unl_tag_seq #(.TAG_W(TAG_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .kick      (start_ok && (|start_mask)),
        .rest_any  (rest_any),
        .last_idx  (last_idx),
        .rd_valid  (tag_rd_valid),
        .rd_ready  (tag_rd_ready),
        .rsp_valid (tag_rsp_valid),
        .rsp_data  (tag_rsp_data),
        .wr_valid  (tag_wr_valid),
        .wr_ready  (tag_wr_ready),
        .wr_data   (tag_wr_data),
        .evt       (evt)
    );

    unl_maint_gate u_gate (
        .busy (busy),
        .req  (maint_valid),
        .resp (mresp)
    );

    assign maint_go  = mresp.go;
    assign maint_err = mresp.err;
endmodule

// File: rtl/unl_checker.sv
module unl_checker #(
    parameter int WAYS  = 16,
    parameter int SETS  = 2048,
    parameter int TAG_W = 24,
    parameter int WAY_W = 4,
    parameter int IDX_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             maint_valid,
    input logic             maint_go,
    input logic             maint_err,
    input logic [31:0]      status,
    input logic             busy,
    input logic             tag_rd_valid,
    input logic             tag_rd_ready,
    input logic             tag_wr_valid,
    input logic             tag_wr_ready,
    input logic [TAG_W-1:0] tag_wr_data,
    input logic [WAY_W-1:0] tag_way,
    input logic [IDX_W-1:0] tag_idx
);
    // R1: upper half of the status word never set
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
        status[31:16] == 16'h0);

    // R2: first cycle out of reset is idle
    p_reset_idle_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status == 32'h0) && !tag_rd_valid && !tag_wr_valid);

    // R2/R3: no tag traffic without a pending way
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tag_rd_valid && !tag_wr_valid);

    // R5: lock flag always cleared in written data
    p_lock_cleared_r5: assert property (@(posedge clk) disable iff (rst)
        tag_wr_valid |-> !tag_wr_data[21]);

    // R6: at most one way finishes per cycle
    p_one_done_r6: assert property (@(posedge clk) disable iff (rst)
        busy |=> $countones($past(status) & ~status) <= 1);

    // R7: refusal while busy, grant while idle
    p_busy_refuse_r7: assert property (@(posedge clk) disable iff (rst)
        (maint_valid && busy) |-> (maint_err && !maint_go));
    p_idle_grant_r7: assert property (@(posedge clk) disable iff (rst)
        (maint_valid && !busy) |-> (maint_go && !maint_err));

    // R8: no status bit rises while busy
    p_no_rise_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> (status & ~$past(status)) == 32'h0);

    // R9: requests hold until accepted
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (tag_rd_valid && !tag_rd_ready) |=> tag_rd_valid && $stable(tag_way) && $stable(tag_idx));
    p_wr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (tag_wr_valid && !tag_wr_ready) |=> tag_wr_valid && $stable(tag_way) && $stable(tag_idx)
            && $stable(tag_wr_data));
endmodule

bind line_unlock_engine unl_checker #(
    .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .WAY_W(WAY_W), .IDX_W(IDX_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .maint_valid  (maint_valid),
    .maint_go     (maint_go),
    .maint_err    (maint_err),
    .status       (status),
    .busy         (busy),
    .tag_rd_valid (tag_rd_valid),
    .tag_rd_ready (tag_rd_ready),
    .tag_wr_valid (tag_wr_valid),
    .tag_wr_ready (tag_wr_ready),
    .tag_wr_data  (tag_wr_data),
    .tag_way      (tag_way),
    .tag_idx      (tag_idx)
);

// File: tb/tb_line_unlock_engine.sv
module tb_line_unlock_engine;
    localparam int WAYS  = 16;
    localparam int SETS  = 4;
    localparam int TAG_W = 24;
    localparam int WAY_W = 4;
    localparam int IDX_W = 2;
    localparam int LOGN  = WAYS * SETS * 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic             start_valid = 1'b0;
    logic [WAYS-1:0]  start_mask  = '0;
    logic             maint_valid = 1'b0;
    logic             maint_go, maint_err, busy;
    logic [31:0]      status;
    logic             tag_rd_valid, tag_wr_valid;
    logic             rd_ready = 1'b0, wr_ready = 1'b0, rsp_valid = 1'b0;
    logic [TAG_W-1:0] rsp_data = '0, tag_wr_data;
    logic [WAY_W-1:0] tag_way;
    logic [IDX_W-1:0] tag_idx;

    line_unlock_engine #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) dut (
        .clk(clk), .rst(rst),
        .start_valid(start_valid), .start_mask(start_mask),
        .maint_valid(maint_valid), .maint_go(maint_go), .maint_err(maint_err),
        .status(status), .busy(busy),
        .tag_rd_valid(tag_rd_valid), .tag_rd_ready(rd_ready),
        .tag_rsp_valid(rsp_valid), .tag_rsp_data(rsp_data),
        .tag_wr_valid(tag_wr_valid), .tag_wr_ready(wr_ready), .tag_wr_data(tag_wr_data),
        .tag_way(tag_way), .tag_idx(tag_idx)
    );

    int total = 0, bad = 0, mon_total = 0, mon_bad = 0;
    bit done = 1'b0;

    function automatic logic [TAG_W-1:0] init_tag(input int w, input int i);
        logic [31:0] v;
        v = (w * 97 + i * 53 + 5) * 2654435;
        v[21] = ((w + i) % 3) != 0;
        return v[TAG_W-1:0];
    endfunction

    // tag RAM model with fixed stall pattern
    logic [TAG_W-1:0] mem [WAYS][SETS];
    int log_way [LOGN];
    int log_idx [LOGN];
    logic [TAG_W-1:0] log_dat [LOGN];
    int  log_n = 0;
    int  cyc = 0;
    logic init_req = 1'b0;
    logic clr_pend = 1'b0, clr_prev = 1'b0;
    int   clr_way = 0;
    logic hold_pend = 1'b0;
    int   hold_way = 0, hold_idx = 0;

    always @(posedge clk) begin
        cyc       <= cyc + 1;
        rd_ready  <= (cyc % 3) != 1;
        wr_ready  <= (cyc % 4) != 2;
        rsp_valid <= 1'b0;
        clr_pend  <= 1'b0;
        hold_pend <= 1'b0;
        if (init_req) begin
            for (int w = 0; w < WAYS; w++)
                for (int i = 0; i < SETS; i++) mem[w][i] <= init_tag(w, i);
            log_n <= 0;
        end else begin
            if (tag_rd_valid && rd_ready) begin
                rsp_valid <= 1'b1;
                rsp_data  <= mem[tag_way][tag_idx];
            end
            if ((tag_rd_valid && !rd_ready) || (tag_wr_valid && !wr_ready)) begin
                hold_pend <= 1'b1;
                hold_way  <= int'(tag_way);
                hold_idx  <= int'(tag_idx);
            end
            if (tag_wr_valid && wr_ready) begin
                mem[tag_way][tag_idx] <= tag_wr_data;
                if (log_n < LOGN) begin
                    log_way[log_n] <= int'(tag_way);
                    log_idx[log_n] <= int'(tag_idx);
                    log_dat[log_n] <= tag_wr_data;
                end
                log_n <= log_n + 1;
                if (int'(tag_idx) == SETS - 1) begin
                    clr_pend <= 1'b1;
                    clr_way  <= int'(tag_way);
                    clr_prev <= status[tag_way];
                end
            end
        end
    end

    // monitor: status bit timing (R6) and request holding (R9)
    always @(negedge clk) begin
        if (clr_pend) begin
            mon_total++;
            if (!(clr_prev == 1'b1 && status[clr_way] == 1'b0)) begin
                mon_bad++;
                $display("FAIL R6 way %0d bit before/after last write: got %b/%b exp 1/0",
                         clr_way, clr_prev, status[clr_way]);
            end
        end
        if (hold_pend) begin
            mon_total++;
            if (!((tag_rd_valid || tag_wr_valid) && int'(tag_way) == hold_way && int'(tag_idx) == hold_idx)) begin
                mon_bad++;
                $display("FAIL R9 stalled request moved: got way %0d idx %0d exp way %0d idx %0d",
                         tag_way, tag_idx, hold_way, hold_idx);
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %h exp %h", req, what, got, exp);
        end
    endtask

    task automatic init_mem();
        @(negedge clk); init_req = 1'b1;
        @(negedge clk); init_req = 1'b0;
    endtask

    task automatic start(input logic [WAYS-1:0] m);
        start_mask = m; start_valid = 1'b1;
        @(negedge clk); start_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
        @(negedge clk);
    endtask

    // verify write order, data and final tag contents for a mask
    task automatic verify(input logic [WAYS-1:0] m, input string tagname);
        int n, errs, exp_n;
        logic [TAG_W-1:0] e;
        n = 0; errs = 0;
        exp_n = $countones(m) * SETS;
        check(log_n == exp_n, "R4", {tagname, " write count"}, log_n, exp_n);
        for (int w = 0; w < WAYS; w++) begin
            if (m[w]) begin
                for (int i = 0; i < SETS; i++) begin
                    if (n < log_n && n < LOGN) begin
                        if (log_way[n] != w || log_idx[n] != i) errs++;
                    end
                    n++;
                end
            end
        end
        check(errs == 0, "R4", {tagname, " visit order mismatches"}, errs, 0);
        errs = 0;
        for (int k = 0; k < log_n && k < LOGN; k++)
            if (log_dat[k] != (init_tag(log_way[k], log_idx[k]) & ~(TAG_W'(1) << 21))) errs++;
        check(errs == 0, "R5", {tagname, " written data mismatches"}, errs, 0);
        errs = 0;
        for (int w = 0; w < WAYS; w++)
            for (int i = 0; i < SETS; i++) begin
                e = m[w] ? (init_tag(w, i) & ~(TAG_W'(1) << 21)) : init_tag(w, i);
                if (mem[w][i] != e) errs++;
            end
        check(errs == 0, "R5", {tagname, " final tag mismatches"}, errs, 0);
        check(status == 32'h0 && !busy, "R6", {tagname, " idle at end"}, status, 0);
    endtask

    task automatic run_mask(input logic [WAYS-1:0] m);
        init_mem();
        start(m);
        check(status == {16'h0, m}, "R3", "status after start", status, {16'h0, m});
        check(busy == (m != '0), "R3", "busy after start", {31'h0, busy}, {31'h0, (m != '0)});
        wait_idle();
        verify(m, "sweep");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(status == 32'h0 && !busy, "R2", "status/busy in reset", status, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!tag_rd_valid && !tag_wr_valid && status == 0, "R2", "idle after reset",
              {30'h0, tag_rd_valid, tag_wr_valid}, 0);

        // R7 idle grant
        maint_valid = 1'b1; #1;
        check(maint_go && !maint_err, "R7", "idle grant go/err", {30'h0, maint_go, maint_err}, 32'h2);
        @(negedge clk); maint_valid = 1'b0;

        // R3 zero mask keeps block idle
        run_mask('0);

        // R1: full mask, upper half zero
        init_mem();
        start(16'hFFFF);
        check(status[31:16] == 16'h0 && status[15:0] == 16'hFFFF, "R1", "status word full mask",
              status, 32'h0000FFFF);
        maint_valid = 1'b1; #1;
        check(maint_err && !maint_go, "R7", "busy refuse go/err", {30'h0, maint_go, maint_err}, 32'h1);
        @(negedge clk); maint_valid = 1'b0;
        wait_idle();
        verify(16'hFFFF, "full");

        // near-exhaustive sweep: every single way, then mixed masks
        for (int w = 0; w < WAYS; w++) run_mask(WAYS'(1) << w);
        run_mask(16'hA5A5);
        run_mask(16'h8001);
        run_mask(16'h0FF0);

        // R8: start while busy is ignored
        init_mem();
        start(16'h0003);
        repeat (2) @(negedge clk);
        start(16'hFFF0);
        check((status & 32'hFFF0) == 32'h0 && busy, "R8", "no bits raised by busy start",
              status, status & 32'h0003);
        wait_idle();
        verify(16'h0003, "R8 busy start");

        // R6/R7 collision: request during final accepted write
        init_mem();
        start(16'h0100);
        for (int k = 0; k < 500; k++) begin
            if (tag_wr_valid && wr_ready && int'(tag_idx) == SETS - 1) break;
            @(negedge clk);
        end
        maint_valid = 1'b1; #1;
        check(maint_err && !maint_go && busy, "R7", "refuse on final write cycle",
              {29'h0, busy, maint_go, maint_err}, 32'h5);
        @(negedge clk); #1;
        check(!busy && status == 0, "R6", "idle cycle after final write", status, 0);
        check(maint_go && !maint_err, "R7", "grant cycle after final write",
              {30'h0, maint_go, maint_err}, 32'h2);
        @(negedge clk); maint_valid = 1'b0;
        verify(16'h0100, "collision");

        done = 1'b1;
        total += mon_total; bad += mon_bad;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout exp completion");
            total += mon_total; bad += mon_bad;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule